// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between locations on a 20-bit byte-addressed memory bus on behalf of two independent channels. Each request, from a software trigger or from an edge on a channel's external request pin, makes the controller acquire the bus, read one unit (a byte or a 16-bit halfword) from the source, write it to the destination and hand the bus back. The CPU therefore loses the bus only for the few cycles of a single unit.

Each channel has a source pointer, a destination pointer, a reload value for its transfer counter and a control word. At most one of the two pointers may step forward; the other stays fixed. The first transfer after a channel is enabled loads the stepping pointer from its register and the counter from the reload value. Each transfer then counts down, and a transfer made at count zero is an underflow, so a reload value of N gives N+1 transfers per block. On underflow the channel pulses its interrupt line. In single mode it then disables itself. In repeat mode it reloads the counter and carries on.

Top module: `dma2ch_ctrl`

## Requirements
- R1: Registers are reached with cfg_addr bit 3 selecting the channel and bits 2:0 selecting the entry: 0 source pointer, 1 destination pointer, 2 reload value (16 bits), 3 control, 4 working counter (read only), 5 working pointer (read only). cfg_rdata shows the entry that was addressed on the previous clock edge. Control bits are: bit 0 enable, bit 1 16-bit unit, bit 2 repeat, bit 3 source steps, bit 4 destination steps, bits 6:5 request source (0 software only, 1 falling edge, 2 both edges, 3 none). Bit 7 is a write-only software trigger that reads as 0. Everything is zero after reset.
- R2: A control write with both bit 3 and bit 4 set is discarded: the stored control word is unchanged and no trigger is taken from it.
- R3: When both channels are pending while the controller is idle, channel 0 is served first.
- R4: A transfer raises bus_req, waits for bus_gnt, then drives bus_rd for one cycle at the source address. The data returned on bus_rdata in the following cycle is driven on bus_wdata with bus_wr for one cycle at the destination address. bus_wide shows the unit size. Then bus_req drops. Each request moves exactly one unit, and a transfer takes at least three cycles from grant.
- R5: After each transfer the stepping pointer advances by 2 for 16-bit units and by 1 for 8-bit units. A fixed pointer keeps its register value.
- R6: The first transfer after enable uses the stepping pointer's register value and the reload value. After k transfers the working counter reads reload − (k mod (reload+1)).
- R7: In single mode a channel makes reload+1 transfers, then clears its enable bit and ignores further requests.
- R8: In repeat mode an underflow reloads the counter, and the channel keeps serving requests with enable still set.
- R9: irq[i] is high for exactly one cycle after each underflow of channel i.
- R10: A request is taken only while enable is 1, and only from the selected source. A software trigger works with any source setting.
- R11: A request that loses arbitration, or arrives while another transfer is running, stays latched and is served later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Channel and register select |
| cfg_wdata | input | 20 | Register write data |
| cfg_rdata | output | 20 | Registered read data |
| ext_req | input | 2 | External request pin per channel |
| irq | output | 2 | Underflow pulse per channel |
| bus_req | output | 1 | Bus request, held for the whole transfer |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wide | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_addr | output | 20 | Byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid the cycle after bus_rd |

## Verification
The hardest situations to reach from the ports are the boundaries of the counter. These are the underflow transfer itself, the extra requests that arrive after a single-mode channel has stopped, and the second block of a repeat-mode channel, which starts from a reloaded counter with a pointer that is not reset. The bench reaches them with a sweep over both channels, both unit sizes, the three legal pointer directions, reload values 0 to 2 and both modes. It fires more edge requests than the block length, varies the grant latency, and computes the expected addresses, data, interrupt counts and final counter and pointer values arithmetically. Directed sequences then drop both request pins in the same cycle, or stagger them during a running transfer, to force arbitration and held requests.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_RD,
    ST_CAP,
    ST_WR
  } seq_state_e;

  localparam logic [2:0] IX_SRC = 3'd0;
  localparam logic [2:0] IX_DST = 3'd1;
  localparam logic [2:0] IX_RLD = 3'd2;
  localparam logic [2:0] IX_CTL = 3'd3;
  localparam logic [2:0] IX_CNT = 3'd4;
  localparam logic [2:0] IX_PTR = 3'd5;

  localparam int unsigned TRIG_BIT = 7;
  localparam int unsigned CTL_W    = 7;

  typedef enum logic [1:0] {
    RS_SOFT = 2'd0,
    RS_FALL = 2'd1,
    RS_BOTH = 2'd2,
    RS_NONE = 2'd3
  } req_sel_e;

  typedef struct packed {
    req_sel_e rsel;
    logic     dst_inc;
    logic     src_inc;
    logic     rpt;
    logic     wide;
    logic     en;
  } chan_ctl_t;

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 16,
  parameter int unsigned RW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [RW-1:0] wr_data,
  input  logic [2:0]    rd_idx,
  output logic [RW-1:0] rd_data,
  input  logic          ext_in,
  input  logic          done,
  output logic          pend_o,
  output logic          wide_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          irq_o
);

  logic [AW-1:0] src_q, dst_q, fptr_q;
  logic [CW-1:0] rld_q, cnt_q;
  chan_ctl_t     ctl_q;
  logic          fresh_q, pend_q, ext_q, irq_q;

  chan_ctl_t     ctl_new;
  logic          wr_ctl, ctl_ok, ctl_acc, sw_trig, hw_trig;
  logic          fall, rise, under, stop;
  logic [CW-1:0] cur_cnt;
  logic [AW-1:0] cur_ptr, step;

  assign ctl_new = chan_ctl_t'(wr_data[CTL_W-1:0]);
  assign wr_ctl  = wr_en && (wr_idx == IX_CTL);
  assign ctl_ok  = !(ctl_new.src_inc && ctl_new.dst_inc);
  assign ctl_acc = wr_ctl && ctl_ok;
  assign sw_trig = ctl_acc && ctl_new.en && wr_data[TRIG_BIT];

  assign fall    = ext_q && !ext_in;
  assign rise    = !ext_q && ext_in;
  assign hw_trig = ctl_q.en && (((ctl_q.rsel == RS_FALL) && fall) ||
                                ((ctl_q.rsel == RS_BOTH) && (fall || rise)));

  assign cur_cnt = fresh_q ? rld_q : cnt_q;
  assign cur_ptr = fresh_q ? (ctl_q.src_inc ? src_q : dst_q) : fptr_q;
  assign under   = (cur_cnt == '0);
  assign stop    = done && under && !ctl_q.rpt;
  assign step    = (ctl_q.src_inc || ctl_q.dst_inc) ?
                   (ctl_q.wide ? AW'(2) : AW'(1)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      dst_q   <= '0;
      fptr_q  <= '0;
      rld_q   <= '0;
      cnt_q   <= '0;
      ctl_q   <= '0;
      fresh_q <= 1'b0;
      pend_q  <= 1'b0;
      ext_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ext_q <= ext_in;
      irq_q <= done && under;
      if (wr_en && wr_idx == IX_SRC) src_q <= wr_data[AW-1:0];
      if (wr_en && wr_idx == IX_DST) dst_q <= wr_data[AW-1:0];
      if (wr_en && wr_idx == IX_RLD) rld_q <= wr_data[CW-1:0];

      if (ctl_acc)   ctl_q    <= ctl_new;
      else if (stop) ctl_q.en <= 1'b0;

      if (ctl_acc && ctl_new.en && !ctl_q.en) fresh_q <= 1'b1;
      else if (done)                          fresh_q <= 1'b0;

      if (done) begin
        fptr_q <= cur_ptr + step;
        cnt_q  <= under ? rld_q : cur_cnt - CW'(1);
      end

      if ((ctl_acc && !ctl_new.en) || (stop && !ctl_acc)) pend_q <= 1'b0;
      else if (sw_trig || hw_trig)                        pend_q <= 1'b1;
      else if (done)                                      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign wide_o = ctl_q.wide;
  assign src_o  = ctl_q.src_inc ? cur_ptr : src_q;
  assign dst_o  = ctl_q.dst_inc ? cur_ptr : dst_q;
  assign irq_o  = irq_q;

  always_comb begin
    case (rd_idx)
      IX_SRC:  rd_data = RW'(src_q);
      IX_DST:  rd_data = RW'(dst_q);
      IX_RLD:  rd_data = RW'(rld_q);
      IX_CTL:  rd_data = RW'(ctl_q);
      IX_CNT:  rd_data = RW'(cnt_q);
      IX_PTR:  rd_data = RW'(fptr_q);
      default: rd_data = '0;
    endcase
  end

  // R2: a control word with both step bits leaves the stored word untouched
  p_incinc_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wr_data[3] && wr_data[4] && !stop) |=> $stable(ctl_q));

  // R7: underflow in single mode drops enable and the pending request
  p_single_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (done && under && !ctl_q.rpt && !wr_ctl) |=> (!ctl_q.en && !pend_q));

  // R8: underflow in repeat mode reloads the counter and keeps the channel on
  p_repeat_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (done && under && ctl_q.rpt && !wr_ctl) |=> (ctl_q.en && cnt_q == $past(rld_q)));

  // R9: the interrupt is a single-cycle pulse
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R10: a disabled channel latches no request unless software writes control
  p_no_req_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.en && !wr_ctl && !pend_q) |=> !pend_q);

endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
  import dma2_pkg::*;
#(
  parameter int unsigned AW  = 20,
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          pend,
  input  logic [NCH-1:0][AW-1:0]  src_a,
  input  logic [NCH-1:0][AW-1:0]  dst_a,
  input  logic [NCH-1:0]          wide,
  output logic [NCH-1:0]          done,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    bus_rd,
  output logic                    bus_wr,
  output logic                    bus_wide,
  output logic [AW-1:0]           bus_addr,
  output logic [DW-1:0]           bus_wdata,
  input  logic [DW-1:0]           bus_rdata
);

  localparam int unsigned OW = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_e    st_q;
  logic [OW-1:0] own_q, pick;

  // lowest channel index has the highest priority
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = OW'(i);
    end
  end

  always_comb begin
    done = '0;
    if (st_q == ST_WR) done[own_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      own_q     <= '0;
      bus_req   <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wide  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (|pend) begin
          own_q   <= pick;
          bus_req <= 1'b1;
          st_q    <= ST_ACQ;
        end
        ST_ACQ: if (bus_gnt) begin
          bus_rd   <= 1'b1;
          bus_addr <= src_a[own_q];
          bus_wide <= wide[own_q];
          st_q     <= ST_RD;
        end
        ST_RD: begin
          bus_rd <= 1'b0;
          st_q   <= ST_CAP;
        end
        ST_CAP: begin
          bus_wdata <= bus_rdata;
          bus_wr    <= 1'b1;
          bus_addr  <= dst_a[own_q];
          st_q      <= ST_WR;
        end
        ST_WR: begin
          bus_wr  <= 1'b0;
          bus_req <= 1'b0;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: channel 0 pending at an idle decision always takes the bus
  p_prio_ch0_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && pend[0]) |=> (own_q == '0));

  // R4: a write strobe comes two cycles after the read strobe
  p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr) |-> $past(bus_rd, 2));

  // R4: the read starts only after the bus was granted
  p_grant_first_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |-> $past(bus_gnt));

  // R4: strobes only while the bus is held
  p_strobe_held_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> bus_req);

endmodule

// File: rtl/dma2ch_ctrl.sv
module dma2ch_ctrl
  import dma2_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic [1:0]    ext_req,
  output logic [1:0]    irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  localparam int unsigned NCH = 2;
  localparam int unsigned RW  = AW;

  logic [NCH-1:0]          pend, wide, done;
  logic [NCH-1:0][AW-1:0]  src_a, dst_a;
  logic [NCH-1:0][RW-1:0]  ch_rd;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma2_chan #(.AW(AW), .CW(CW), .RW(RW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we && (cfg_addr[3] == 1'(g))),
      .wr_idx  (cfg_addr[2:0]),
      .wr_data (cfg_wdata),
      .rd_idx  (cfg_addr[2:0]),
      .rd_data (ch_rd[g]),
      .ext_in  (ext_req[g]),
      .done    (done[g]),
      .pend_o  (pend[g]),
      .wide_o  (wide[g]),
      .src_o   (src_a[g]),
      .dst_o   (dst_a[g]),
      .irq_o   (irq[g])
    );
  end

  dma2_seq #(.AW(AW), .DW(DW), .NCH(NCH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .src_a     (src_a),
    .dst_a     (dst_a),
    .wide      (wide),
    .done      (done),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= ch_rd[cfg_addr[3]];
  end

  // R9: the two channels can never underflow in the same cycle
  p_irq_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));

endmodule

// File: tb/dma2ch_ctrl_test.sv
module dma2ch_ctrl_test;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_rdata;
  logic [1:0]  ext_req = '0;
  logic [1:0]  irq;
  logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_wide;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;

  int total = 0;
  int bad   = 0;
  int gdly  = 0;
  int wcnt = 0, rcnt = 0, ic0 = 0, ic1 = 0;
  logic [1:0]  gcnt = '0;
  logic [19:0] wla [1024];
  logic [15:0] wld [1024];
  logic        wlw [1024];
  logic [19:0] rla [1024];

  always #(CLK_NS / 2) clk = ~clk;

  dma2ch_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_req(ext_req),
    .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h9} ^ 8'h3C;
  endfunction

  assign bus_gnt = bus_req && (int'(gcnt) >= gdly);

  always @(posedge clk) begin
    gcnt <= bus_req ? ((gcnt == 2'd3) ? gcnt : gcnt + 2'd1) : 2'd0;
    if (bus_rd) begin
      bus_rdata <= {pat(bus_addr + 20'd1), pat(bus_addr)};
      rla[rcnt % 1024] <= bus_addr;
      rcnt <= rcnt + 1;
    end
    if (bus_wr) begin
      wla[wcnt % 1024] <= bus_addr;
      wld[wcnt % 1024] <= bus_wdata;
      wlw[wcnt % 1024] <= bus_wide;
      wcnt <= wcnt + 1;
    end
    if (irq[0]) ic0 <= ic0 + 1;
    if (irq[1]) ic1 <= ic1 + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] ctl(input int en, input int wide, input int rpt,
                                      input int si, input int di, input int rs, input int trig);
    return 20'({trig[0], rs[1:0], di[0], si[0], rpt[0], wide[0], en[0]});
  endfunction

  task automatic wr_reg(input int ch, input int idx, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {ch[0], idx[2:0]}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input int idx, output logic [19:0] v);
    @(negedge clk);
    cfg_addr = {ch[0], idx[2:0]};
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); ext_req[ch] = 1'b1;
    @(negedge clk); ext_req[ch] = 1'b0;
    idle(10);
  endtask

  initial begin : watchdog
    #(CLK_NS * 190000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [19:0] v;
    int w0, r0, i0, n_exp;
    idle(3);
    rst = 1'b0;
    idle(1);
    // reset state
    chk(irq == 2'b00, "R9 irq after reset", irq, 0);
    chk(!bus_req && !bus_rd && !bus_wr, "R4 bus idle after reset", {bus_req, bus_rd, bus_wr}, 0);
    rd_reg(0, 3, v); chk(v == 0, "R1 ctl reset", v, 0);
    rd_reg(1, 0, v); chk(v == 0, "R1 src reset", v, 0);

    // R1 readback
    wr_reg(1, 0, 20'hABCDE); rd_reg(1, 0, v); chk(v == 20'hABCDE, "R1 src readback", v, 20'hABCDE);
    wr_reg(1, 2, 20'h7BEEF); rd_reg(1, 2, v); chk(v == 20'h0BEEF, "R1 reload 16 bit", v, 20'h0BEEF);
    wr_reg(1, 3, ctl(0, 1, 1, 1, 0, 2, 1));
    rd_reg(1, 3, v); chk(v == ctl(0, 1, 1, 1, 0, 2, 0), "R1 ctl readback", v, ctl(0, 1, 1, 1, 0, 2, 0));
    // R2 both pointers stepping is refused
    w0 = wcnt;
    wr_reg(1, 3, ctl(1, 0, 0, 1, 1, 0, 1));
    idle(10);
    rd_reg(1, 3, v); chk(v == ctl(0, 1, 1, 1, 0, 2, 0), "R2 ctl unchanged", v, ctl(0, 1, 1, 1, 0, 2, 0));
    chk(wcnt == w0, "R2 no transfer", wcnt - w0, 0);
    wr_reg(1, 3, 0);

    // sweep: R5 R6 R7 R8 R9 R4
    for (int ch = 0; ch < 2; ch++)
      for (int wd = 0; wd < 2; wd++)
        for (int md = 0; md < 3; md++)
          for (int n = 0; n < 3; n++)
            for (int rp = 0; rp < 2; rp++) begin
              int t_cnt, step, si, di;
              logic [19:0] bs, bd;
              gdly = (ch + md + n) % 3;
              si = (md == 0) ? 1 : 0;
              di = (md == 1) ? 1 : 0;
              step = wd ? 2 : 1;
              bs = 20'h3_0040 + 20'(n * 16 + ch * 256);
              bd = 20'h5_0080 + 20'(md * 32 + wd * 512);
              wr_reg(ch, 3, 0);
              wr_reg(ch, 0, bs);
              wr_reg(ch, 1, bd);
              wr_reg(ch, 2, 20'(n));
              wr_reg(ch, 3, ctl(1, wd, rp, si, di, 1, 0));
              w0 = wcnt; r0 = rcnt; i0 = ch ? ic1 : ic0;
              t_cnt = rp ? 2 * (n + 1) + 1 : n + 3;
              for (int t = 0; t < t_cnt; t++) pulse(ch);
              n_exp = rp ? t_cnt : n + 1;
              chk(wcnt - w0 == n_exp, rp ? "R8 transfer count" : "R7 transfer count", wcnt - w0, n_exp);
              for (int k = 0; k < n_exp; k++) begin
                logic [19:0] es, ed;
                es = bs + 20'(si ? k * step : 0);
                ed = bd + 20'(di ? k * step : 0);
                chk(rla[(r0 + k) % 1024] == es, "R5 source address", rla[(r0 + k) % 1024], es);
                chk(wla[(w0 + k) % 1024] == ed, "R5 dest address", wla[(w0 + k) % 1024], ed);
                chk(wld[(w0 + k) % 1024][7:0] == pat(es), "R4 low byte", wld[(w0 + k) % 1024][7:0], pat(es));
                if (wd) chk(wld[(w0 + k) % 1024][15:8] == pat(es + 20'd1), "R4 high byte",
                            wld[(w0 + k) % 1024][15:8], pat(es + 20'd1));
                chk(wlw[(w0 + k) % 1024] == wd[0], "R4 unit size", wlw[(w0 + k) % 1024], wd);
              end
              chk((ch ? ic1 : ic0) - i0 == (rp ? t_cnt / (n + 1) : 1), "R9 irq count",
                  (ch ? ic1 : ic0) - i0, rp ? t_cnt / (n + 1) : 1);
              rd_reg(ch, 3, v);
              chk(v[0] == rp[0], rp ? "R8 still enabled" : "R7 enable cleared", v[0], rp);
              rd_reg(ch, 4, v);
              chk(v == 20'(n - (n_exp % (n + 1))), "R6 working counter", v, n - (n_exp % (n + 1)));
              if (md != 2) begin
                rd_reg(ch, 5, v);
                chk(v == (si ? bs : bd) + 20'(n_exp * step), "R5 working pointer", v,
                    (si ? bs : bd) + 20'(n_exp * step));
              end
              wr_reg(ch, 3, 0);
            end

    // R3 and R11: simultaneous requests
    gdly = 1;
    wr_reg(0, 0, 20'h0_1000); wr_reg(0, 1, 20'h0_2000); wr_reg(0, 2, 0);
    wr_reg(1, 0, 20'h0_3000); wr_reg(1, 1, 20'h0_4000); wr_reg(1, 2, 0);
    wr_reg(0, 3, ctl(1, 0, 1, 0, 0, 1, 0));
    wr_reg(1, 3, ctl(1, 0, 1, 0, 0, 1, 0));
    r0 = rcnt;
    @(negedge clk); ext_req = 2'b11;
    @(negedge clk); ext_req = 2'b00;
    idle(24);
    chk(rcnt - r0 == 2, "R11 both served", rcnt - r0, 2);
    chk(rla[r0 % 1024] == 20'h0_1000, "R3 channel 0 first", rla[r0 % 1024], 20'h0_1000);
    chk(rla[(r0 + 1) % 1024] == 20'h0_3000, "R11 channel 1 later", rla[(r0 + 1) % 1024], 20'h0_3000);
    // channel 1 running, channel 0 request arrives and waits
    r0 = rcnt;
    @(negedge clk); ext_req = 2'b10;
    @(negedge clk); ext_req = 2'b00;
    idle(2);
    @(negedge clk); ext_req = 2'b01;
    @(negedge clk); ext_req = 2'b00;
    idle(24);
    chk(rcnt - r0 == 2, "R11 held request served", rcnt - r0, 2);
    chk(rla[r0 % 1024] == 20'h0_3000, "R11 running transfer kept", rla[r0 % 1024], 20'h0_3000);

    // R10 request sources
    gdly = 0;
    w0 = wcnt;
    wr_reg(0, 3, ctl(1, 0, 1, 0, 0, 0, 1));
    idle(10);
    chk(wcnt - w0 == 1, "R10 software trigger", wcnt - w0, 1);
    w0 = wcnt; pulse(0);
    chk(wcnt - w0 == 0, "R10 edge ignored when software selected", wcnt - w0, 0);
    wr_reg(0, 3, ctl(1, 0, 1, 0, 0, 2, 0));
    w0 = wcnt;
    @(negedge clk); ext_req[0] = 1'b1; idle(10);
    chk(wcnt - w0 == 1, "R10 rising edge in both-edge mode", wcnt - w0, 1);
    @(negedge clk); ext_req[0] = 1'b0; idle(10);
    chk(wcnt - w0 == 2, "R10 falling edge in both-edge mode", wcnt - w0, 2);
    wr_reg(0, 3, ctl(1, 0, 1, 0, 0, 1, 0));
    w0 = wcnt;
    @(negedge clk); ext_req[0] = 1'b1; idle(10);
    chk(wcnt - w0 == 0, "R10 rising edge ignored in falling mode", wcnt - w0, 0);
    @(negedge clk); ext_req[0] = 1'b0; idle(10);
    wr_reg(0, 3, ctl(0, 0, 1, 0, 0, 1, 0));
    w0 = wcnt;
    pulse(0);
    wr_reg(0, 3, ctl(0, 0, 1, 0, 0, 0, 1));
    idle(10);
    chk(wcnt - w0 == 0, "R10 disabled channel ignores requests", wcnt - w0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule